// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Timer

This block times the register and data strobes for one parallel ATA channel that carries two devices. All counts are in periods of a 33 MHz reference clock, about 30 ns each. Each device has a data timing byte, which holds an active-strobe count and a recovery count. Each device also has a 2-bit address-setup code. Software computes these values and loads them through a byte-wide write port.

A request names the target device and the direction. On a request, the block takes that device's timing and runs three phases in a fixed order. First comes address setup with both strobes high. Next the read or write strobe is held low for the active count. Last comes recovery with the strobes high again. In the final recovery clock the block raises a one-clock done pulse.

The parameter `SHARED_SETUP` picks the channel variant. When it is 0, each device has its own setup register (primary channel). When it is 1, both devices read one common setup register, as the secondary channel requires. Software must then load that register with the longer of the two devices' setup needs.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset both strobes are high, `busy_o` and `done_o` are low, and every device times as setup code 11, active 16, recovery 16. A first cycle with no writes therefore lasts 5 + 16 + 16 clocks.
- R2: Write address map. Address 0 is the device 0 data byte and address 1 is the device 1 data byte. Address 2 is the device 0 setup register and address 3 is the device 1 setup register. A register is written when `wr_en_i` is high at a rising clock edge.
- R3: The active count sits in data bits 7:4. A value of 0 gives 16 clocks, and a value n from 1 to 15 gives n clocks.
- R4: The recovery count sits in data bits 3:0. A value of 0 gives 16 clocks, a value n from 1 to 14 gives n+1 clocks, and a value of 15 gives 1 clock.
- R5: The setup code sits in bits 7:6 of a setup register. Code 01 gives 2 clocks, 10 gives 3, 00 gives 4, and 11 gives `SETUP_LONG_CLKS` clocks (default 5). Bits 5:0 of that register have no effect on timing.
- R6: A cycle runs setup, then active, then recovery. During the active phase only `dior_n_o` is low for a read (`req_write_i` = 0), or only `diow_n_o` for a write (`req_write_i` = 1). The other strobe stays high throughout.
- R7: `done_o` is high for exactly one clock, in the last recovery clock. `busy_o` is low on the following clock.
- R8: A request is accepted only while the block is idle. `req_i` asserted during a cycle is ignored, and no extra cycle results from it.
- R9: Timing is captured when a request is accepted. A register write made during a running cycle applies only from the next request.
- R10: With `SHARED_SETUP`=1, writes to address 2 or 3 update one setup register that both devices use. With `SHARED_SETUP`=0, the two setup registers are independent.
- R11: A cycle uses the timing of the device given by `req_dev_i`, and `dev_o` reports that device for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 33 MHz timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Timing register write enable |
| wr_addr_i | input | 2 | Timing register address |
| wr_data_i | input | 8 | Timing register write data |
| req_i | input | 1 | Start a transfer cycle (taken when idle) |
| req_dev_i | input | 1 | Target device of the request |
| req_write_i | input | 1 | 1 = write strobe, 0 = read strobe |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse in the final recovery clock |
| dev_o | output | 1 | Device of the running cycle |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |

## Verification
The bench builds two instances side by side. One uses `SHARED_SETUP`=0 and the other `SHARED_SETUP`=1, both with the default 5-clock long setup. This lets the same write to address 3 be checked against both variants: it must change the other device's setup on the shared channel and must leave it alone on the independent one. For each cycle the scoreboard measures the setup, active and recovery lengths from the strobes and the done pulse. That covers the wrap points of the encodings: active 0 and 15, recovery 0, 14 and 15, and all four setup codes.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int unsigned CNT_W    = 5;
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned MAX_CLKS = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_RECOV  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } clk_counts_t;

  function automatic logic [CNT_W-1:0] active_clks(input logic [FIELD_W-1:0] f);
    return (f == '0) ? CNT_W'(MAX_CLKS) : CNT_W'(f);
  endfunction

  // 0 wraps to the maximum, all-ones is the short-recovery code
  function automatic logic [CNT_W-1:0] recov_clks(input logic [FIELD_W-1:0] f);
    if (f == '0)      return CNT_W'(MAX_CLKS);
    else if (&f)      return CNT_W'(1);
    else              return CNT_W'(f) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] code,
                                                  input logic [CNT_W-1:0] long_clks);
    case (code)
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(3);
      2'b00:   return CNT_W'(4);
      default: return long_clks;
    endcase
  endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_timer_pkg::*;
#(
  parameter bit          SHARED_SETUP = 1'b0,
  parameter int unsigned NUM_DEV      = 2,
  parameter int unsigned DATA_W       = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(NUM_DEV):0]   wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [DATA_W-1:0]          data_tim_o [NUM_DEV],
  output logic [1:0]                 setup_code_o [NUM_DEV]
);

  localparam int unsigned DEV_W     = $clog2(NUM_DEV);
  localparam int unsigned ADDR_W    = DEV_W + 1;
  localparam int unsigned NUM_SETUP = SHARED_SETUP ? 1 : NUM_DEV;
  localparam logic [DATA_W-1:0] DATA_RST  = '0;   // active 16, recovery 16
  localparam logic [1:0]        SETUP_RST = 2'b11;

  logic              grp_setup;
  logic [DEV_W-1:0]  wr_dev;
  logic [1:0]        setup_q [NUM_SETUP];

  assign grp_setup = wr_addr_i[ADDR_W-1];
  assign wr_dev    = wr_addr_i[DEV_W-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_data
    logic [DATA_W-1:0] data_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          data_q <= DATA_RST;
      else if (wr_en_i && !grp_setup && wr_dev == DEV_W'(d)) data_q <= wr_data_i;
    end
    assign data_tim_o[d]   = data_q;
    assign setup_code_o[d] = setup_q[SHARED_SETUP ? 0 : d];
  end

  for (genvar s = 0; s < NUM_SETUP; s++) begin : g_setup
    logic hit;
    assign hit = wr_en_i && grp_setup && (SHARED_SETUP || wr_dev == DEV_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  setup_q[s] <= SETUP_RST;
      else if (hit) setup_q[s] <= wr_data_i[DATA_W-1 -: 2];
    end
  end

  if (SHARED_SETUP) begin : g_shared_chk
    AST_SHARED_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      setup_code_o[0] == setup_code_o[NUM_DEV-1]) else $error("shared setup split"); // R10
  end

endmodule

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_timer_pkg::*;
#(
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned SETUP_LONG_CLKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_tim_i,
  input  logic [1:0]        setup_code_i,
  output clk_counts_t       counts_o
);

  localparam logic [CNT_W-1:0] LONG_CLKS = CNT_W'(SETUP_LONG_CLKS);

  assign counts_o.active = active_clks(data_tim_i[DATA_W-1 -: FIELD_W]);
  assign counts_o.recov  = recov_clks(data_tim_i[FIELD_W-1:0]);
  assign counts_o.setup  = setup_clks(setup_code_i, LONG_CLKS);

  AST_ACTIVE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counts_o.active != '0 && counts_o.active <= CNT_W'(MAX_CLKS)) else $error("active range"); // R3
  AST_RECOV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counts_o.recov != '0 && counts_o.recov <= CNT_W'(MAX_CLKS)) else $error("recov range"); // R4
  AST_SETUP_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counts_o.setup >= CNT_W'(2)) else $error("setup range"); // R5

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
  import pio_timer_pkg::*;
#(
  parameter int unsigned DEV_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DEV_W-1:0] req_dev_i,
  input  logic             req_write_i,
  input  clk_counts_t      counts_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DEV_W-1:0] dev_o,
  output logic             dior_n_o,
  output logic             diow_n_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q, rec_q;
  logic [DEV_W-1:0] dev_q;
  logic             wr_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      dev_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_SETUP;
          cnt_q   <= counts_i.setup - CNT_W'(1);
          act_q   <= counts_i.active;
          rec_q   <= counts_i.recov;
          dev_q   <= req_dev_i;
          wr_q    <= req_write_i;
        end
        ST_SETUP: if (last) begin
          state_q <= ST_ACTIVE;
          cnt_q   <= act_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_ACTIVE: if (last) begin
          state_q <= ST_RECOV;
          cnt_q   <= rec_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: if (last) state_q <= ST_IDLE;
                 else      cnt_q   <= cnt_q - CNT_W'(1);
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_RECOV) && last;
  assign dev_o    = dev_q;
  assign dior_n_o = !((state_q == ST_ACTIVE) && !wr_q);
  assign diow_n_o = !((state_q == ST_ACTIVE) && wr_q);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dior_n_o || diow_n_o) else $error("both strobes low"); // R6
  AST_SETUP_BEFORE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dior_n_o && diow_n_o) |-> $past(busy_o)) else $error("strobe without setup"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o) else $error("done not single"); // R7
  AST_DONE_STROBES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dior_n_o && diow_n_o) else $error("done during strobe"); // R7
  AST_DEV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(dev_o)) else $error("device changed mid-cycle"); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_CLKS)) else $error("counter overflow"); // R3

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter bit          SHARED_SETUP    = 1'b0,
  parameter int unsigned SETUP_LONG_CLKS = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       req_i,
  input  logic       req_dev_i,
  input  logic       req_write_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       dev_o,
  output logic       dior_n_o,
  output logic       diow_n_o
);

  localparam int unsigned NUM_DEV = 2;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned DEV_W   = $clog2(NUM_DEV);

  logic [DATA_W-1:0] data_tim   [NUM_DEV];
  logic [1:0]        setup_code [NUM_DEV];
  clk_counts_t       counts     [NUM_DEV];
  clk_counts_t       sel_counts;

  pio_timing_regs #(
    .SHARED_SETUP (SHARED_SETUP),
    .NUM_DEV      (NUM_DEV),
    .DATA_W       (DATA_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .data_tim_o   (data_tim),
    .setup_code_o (setup_code)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dec
    pio_timing_decode #(
      .DATA_W          (DATA_W),
      .SETUP_LONG_CLKS (SETUP_LONG_CLKS)
    ) u_dec (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .data_tim_i   (data_tim[d]),
      .setup_code_i (setup_code[d]),
      .counts_o     (counts[d])
    );
  end

  assign sel_counts = counts[req_dev_i];

  pio_cycle_seq #(
    .DEV_W (DEV_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_dev_i   (req_dev_i),
    .req_write_i (req_write_i),
    .counts_i    (sel_counts),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .dev_o       (dev_o),
    .dior_n_o    (dior_n_o),
    .diow_n_o    (diow_n_o)
  );

endmodule

// File: tb/pio_cycle_timer_tb_top.sv
module pio_cycle_timer_tb_top;

  typedef struct {
    int s;
    int a;
    int r;
    bit w;
    bit dev;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en [2];
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       req [2];
  logic       req_dev, req_write;
  logic       busy [2], done [2], dev [2], rd_n [2], wr_n [2];

  int n_chk = 0, n_fail = 0;
  exp_t q0[$], q1[$];

  // bench-side register model: [instance][device]
  logic [7:0] data_m  [2][2];
  logic [1:0] setup_m [2][2];

  pio_cycle_timer #(.SHARED_SETUP(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[0]), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .req_i(req[0]), .req_dev_i(req_dev), .req_write_i(req_write),
    .busy_o(busy[0]), .done_o(done[0]), .dev_o(dev[0]), .dior_n_o(rd_n[0]), .diow_n_o(wr_n[0]));

  pio_cycle_timer #(.SHARED_SETUP(1'b1)) dut_sh_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[1]), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .req_i(req[1]), .req_dev_i(req_dev), .req_write_i(req_write),
    .busy_o(busy[1]), .done_o(done[1]), .dev_o(dev[1]), .dior_n_o(rd_n[1]), .diow_n_o(wr_n[1]));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int m_act(input logic [3:0] f);
    return (f == 0) ? 16 : int'(f);
  endfunction
  function automatic int m_rec(input logic [3:0] f);
    if (f == 0) return 16;
    if (f == 15) return 1;
    return int'(f) + 1;
  endfunction
  function automatic int m_set(input logic [1:0] c);
    case (c)
      2'b01: return 2;
      2'b10: return 3;
      2'b00: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic reg_wr(input int inst, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en[inst] = 1'b1;
    @(negedge clk);
    wr_en[inst] = 1'b0;
    if (a[1] == 1'b0) data_m[inst][a[0]] = d;
    else if (inst == 1) begin setup_m[1][0] = d[7:6]; setup_m[1][1] = d[7:6]; end
    else setup_m[0][a[0]] = d[7:6];
  endtask

  // drive a request for one clock and push the expected item
  task automatic issue(input int inst, input bit d, input bit w, input string tag);
    exp_t e;
    e.s = m_set(setup_m[inst][d]);
    e.a = m_act(data_m[inst][d][7:4]);
    e.r = m_rec(data_m[inst][d][3:0]);
    e.w = w; e.dev = d; e.tag = tag;
    if (inst == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    req_dev = d; req_write = w; req[inst] = 1'b1;
    @(negedge clk);
    req[inst] = 1'b0;
  endtask

  task automatic wait_idle(input int inst);
    while (busy[inst]) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  int  s_c [2], a_c [2], r_c [2];
  bit  seen [2], wr_seen [2], exp_idle [2];

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (exp_idle[i]) begin
          chk(!busy[i] && !done[i], "R7", "busy/done after done pulse", int'(busy[i]), 0);
          exp_idle[i] = 1'b0;
        end
        if (busy[i]) begin
          if (!rd_n[i] || !wr_n[i]) begin
            seen[i] = 1'b1; a_c[i]++; wr_seen[i] = !wr_n[i];
            if (!rd_n[i] && !wr_n[i]) chk(1'b0, "R6", "both strobes low", 1, 0);
          end else if (!seen[i]) s_c[i]++;
          else r_c[i]++;
          if (done[i]) begin
            exp_t e;
            int have;
            have = (i == 0) ? q0.size() : q1.size();
            if (have == 0) chk(1'b0, "R8", "unexpected cycle completed", 1, 0);
            else begin
              if (i == 0) e = q0.pop_front(); else e = q1.pop_front();
              chk(s_c[i] == e.s, "R5", {e.tag, " setup clocks"}, s_c[i], e.s);
              chk(a_c[i] == e.a, "R3", {e.tag, " active clocks"}, a_c[i], e.a);
              chk(r_c[i] == e.r, "R4", {e.tag, " recovery clocks"}, r_c[i], e.r);
              chk(wr_seen[i] == e.w, "R6", {e.tag, " strobe kind"}, int'(wr_seen[i]), int'(e.w));
              chk(dev[i] == e.dev, "R11", {e.tag, " device"}, int'(dev[i]), int'(e.dev));
            end
            exp_idle[i] = 1'b1;
          end
        end else begin
          s_c[i] = 0; a_c[i] = 0; r_c[i] = 0; seen[i] = 1'b0; wr_seen[i] = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      wr_en[i] = 1'b0; req[i] = 1'b0;
      for (int d = 0; d < 2; d++) begin data_m[i][d] = 8'h00; setup_m[i][d] = 2'b11; end
    end
    wr_addr = '0; wr_data = '0; req_dev = 1'b0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(!busy[i] && !done[i], "R1", "reset busy/done", int'(busy[i]), 0);
      chk(rd_n[i] && wr_n[i], "R1", "reset strobes high", int'(rd_n[i] & wr_n[i]), 1);
    end

    issue(0, 1'b0, 1'b0, "R1 default dev0");  wait_idle(0);
    issue(1, 1'b1, 1'b1, "R1 default dev1");  wait_idle(1);

    // R2 R3 R4 R5: distinct codes per device
    reg_wr(0, 2'd0, 8'h35);
    reg_wr(0, 2'd2, 8'h40);
    issue(0, 1'b0, 1'b0, "R2 dev0 a3 r6 s2"); wait_idle(0);
    issue(0, 1'b1, 1'b1, "R11 dev1 untouched"); wait_idle(0);

    // R4 code 15 -> 1, R5 code 10 with junk in low bits
    reg_wr(0, 2'd1, 8'h1F);
    reg_wr(0, 2'd3, 8'hBF);
    issue(0, 1'b1, 1'b1, "R4 r15 wrap"); wait_idle(0);

    // R3 max field, R4 0 -> 16, R5 code 00
    reg_wr(0, 2'd1, 8'hF0);
    reg_wr(0, 2'd3, 8'h15);
    issue(0, 1'b1, 1'b0, "R3 a15 r16 s4"); wait_idle(0);

    // R3 0 -> 16, R4 14 -> 15
    reg_wr(0, 2'd0, 8'h0E);
    issue(0, 1'b0, 1'b1, "R3 a16 r15"); wait_idle(0);

    // R8: request held into a running cycle is ignored
    reg_wr(0, 2'd0, 8'h43);
    q0.push_back('{s: 2, a: 4, r: 4, w: 1'b0, dev: 1'b0, tag: "R8 first"});
    @(negedge clk);
    req_dev = 1'b0; req_write = 1'b0; req[0] = 1'b1;
    @(negedge clk);
    req_dev = 1'b1; req_write = 1'b1;
    repeat (4) @(negedge clk);
    req[0] = 1'b0;
    wait_idle(0);
    repeat (3) begin
      chk(!busy[0], "R8", "no extra cycle", int'(busy[0]), 0);
      @(negedge clk);
    end

    // R9: write during a cycle applies from the next request
    issue(0, 1'b0, 1'b0, "R9 old timing");
    reg_wr(0, 2'd0, 8'h21);
    wait_idle(0);
    issue(0, 1'b0, 1'b0, "R9 new timing"); wait_idle(0);

    // R10: address 3 on the shared instance moves device 0 too
    reg_wr(1, 2'd3, 8'h40);
    issue(1, 1'b0, 1'b0, "R10 shared dev0"); wait_idle(1);
    issue(1, 1'b1, 1'b1, "R10 shared dev1"); wait_idle(1);
    reg_wr(1, 2'd2, 8'h80);
    issue(1, 1'b1, 1'b0, "R10 shared via addr2"); wait_idle(1);
    // independent instance: address 3 leaves device 0 alone
    reg_wr(0, 2'd3, 8'hC0);
    issue(0, 1'b0, 1'b1, "R10 independent dev0"); wait_idle(0);

    repeat (2) @(negedge clk);
    chk(q0.size() == 0, "R8", "pending items inst0", q0.size(), 0);
    chk(q1.size() == 0, "R8", "pending items inst1", q1.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule